// File: doc/BRIEF.md
# In-Place Block Ring Buffer

This block is one circular byte store shared by three parties. A producer streams bytes in. A block engine fetches 16-byte blocks from the store. The engine writes each result block back over the same 16 bytes it came from. A consumer then streams the processed bytes out. Four pointers travel around the ring in a fixed order, each chasing the next one: the consumer read offset, the engine store index, the engine fetch index and the producer write offset. The two byte offsets move one byte per transfer. The two engine indices count 32-bit words and move four words, which is one block, per transfer.

All four data interfaces use valid/ready. A transfer happens on a rising clock edge when both valid and ready are high. Every valid and ready that the block drives depends only on its registered pointers and never on the partner's signal in the same cycle. Once the block raises `fet_valid` or `rd_valid`, the signal stays high and its data stays unchanged until the transfer is taken. Control and status pins are plain levels.

Top module: `inplace_ring`

## Requirements
- R1: `wr_ready` is high while fewer than BUF_BYTES-1 bytes are held (bytes held is the distance from the read offset to the write offset). The buffer therefore accepts at most BUF_BYTES-1 bytes and the write offset never lands on the read offset. `free_bytes` equals BUF_BYTES-1 minus the bytes held.
- R2: `fet_valid` is high exactly when at least 16 bytes lie between the fetch point and the write offset. Byte j of the block, at bits [8j+7:8j] of `fet_data`, is the byte at ring byte position fetch+j, and the 32-bit word k sits at bits [32k+31:32k]. A fetch advances the fetch index by 4 words.
- R3: `sto_ready` is high exactly when at least one fetched block has not yet been stored. A store writes `sto_data`, with the same byte layout as R2, over the 16 bytes at the store index and advances that index by 4 words.
- R4: `rd_valid` is high exactly when the store index is ahead of the read offset. `rd_data` is the byte at the read offset, and bytes come out in ring order.
- R5: Engine indices wrap to zero when they reach the buffer length in words. Byte offsets wrap at BUF_BYTES. Data stays continuous across the end of the ring.
- R6: `refill_req` is high when fewer than 16 bytes lie between the fetch point and the write offset.
- R7: `drain_req` is high when `rd_avail` is at least BUF_BYTES-32, or when it is at least `rd_req_len`.
- R8: `stall` is high when no fetch is offered and no fetched block is waiting to be stored.
- R9: `order_fault` is high if, going around the ring from the read offset, the order read ≤ store ≤ fetch ≤ write does not hold. It stays low under legal traffic.
- R10: A high `clr` at a clock edge sets all four pointers to zero. Afterwards `free_bytes` is BUF_BYTES-1, `eng_blocks` and `rd_avail` are 0, and `stall` and `refill_req` are high.
- R11: `eng_blocks` reports whole blocks ready for the engine. `rd_avail` reports the bytes between the read offset and the store point.
- R12: While `fet_valid` or `rd_valid` is high and the transfer is not taken, the valid stays high and the data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all pointers |
| wr_valid | input | 1 | Producer byte valid |
| wr_ready | output | 1 | Space for one more byte |
| wr_data | input | 8 | Producer byte |
| fet_valid | output | 1 | A block is ready for the engine |
| fet_ready | input | 1 | Engine takes the block |
| fet_data | output | 128 | Block at the fetch index |
| sto_valid | input | 1 | Engine result valid |
| sto_ready | output | 1 | A fetched block awaits its result |
| sto_data | input | 128 | Result block, written in place |
| rd_valid | output | 1 | Processed byte available |
| rd_ready | input | 1 | Consumer takes the byte |
| rd_data | output | 8 | Byte at the read offset |
| rd_req_len | input | LEN_W | Pending consumer request length in bytes |
| free_bytes | output | AW+1 | Bytes the producer may still write |
| eng_blocks | output | AW+1 | Whole blocks ready to fetch |
| rd_avail | output | AW+1 | Processed bytes ready to read |
| refill_req | output | 1 | Engine is short of input |
| drain_req | output | 1 | Consumer should collect output |
| stall | output | 1 | Neither fetch nor store is possible |
| order_fault | output | 1 | Pointer order violated |

## Verification
The bench first fills the ring to its last usable byte. An off-by-one in the free-space rule shows up here: such a design would accept the 256th byte, the write offset would collide with the read offset, and the ring would look empty. The bench then processes that almost-full ring into the state where 240 bytes are ready and 15 bytes are left over. A wrong drain threshold would leave `drain_req` low there, and a wrong stall or refill rule would miss the condition where the engine has no work. Long random traffic then carries every pointer across the ring end many times. A pointer that wraps at the wrong count, or a lane ordering that is mirrored, corrupts the byte stream, and the bench detects this against a generated pattern. Ready signals are held low over several cycles to show that held data stays steady, and a mid-run clear must leave a clean empty ring.

// File: rtl/inplace_ring_pkg.sv
package inplace_ring_pkg;
  localparam int unsigned BLK_BYTES  = 16;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned BLK_WORDS  = BLK_BYTES / WORD_BYTES;
  localparam int unsigned BLK_BITS   = BLK_BYTES * 8;
  localparam int unsigned DRAIN_SLACK = 32;
endpackage

// File: rtl/inplace_ring_store.sv
module inplace_ring_store
  import inplace_ring_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 256,
  localparam int unsigned AW = $clog2(BUF_BYTES),
  localparam int unsigned BW = AW - 4
) (
  input  logic                clk,
  input  logic                byte_we,
  input  logic [AW-1:0]       byte_waddr,
  input  logic [7:0]          byte_wdata,
  input  logic                blk_we,
  input  logic [BW-1:0]       blk_waddr,
  input  logic [BLK_BITS-1:0] blk_wdata,
  input  logic [AW-1:0]       byte_raddr,
  output logic [7:0]          byte_rdata,
  input  logic [BW-1:0]       blk_raddr,
  output logic [BLK_BITS-1:0] blk_rdata
);
  logic [7:0] mem [BUF_BYTES];

  // Producer and engine regions never overlap, so both writes may land together.
  always_ff @(posedge clk) begin
    if (byte_we) mem[byte_waddr] <= byte_wdata;
    if (blk_we) begin
      for (int j = 0; j < BLK_BYTES; j++)
        mem[{blk_waddr, 4'(j)}] <= blk_wdata[8*j +: 8];
    end
  end

  assign byte_rdata = mem[byte_raddr];

  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
    localparam logic [3:0] LANE = 4'(g);
    assign blk_rdata[8*g +: 8] = mem[{blk_raddr, LANE}];
  end
endmodule

// File: rtl/inplace_ring_ptrs.sv
module inplace_ring_ptrs
  import inplace_ring_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 256,
  localparam int unsigned AW = $clog2(BUF_BYTES),
  localparam int unsigned WW = AW - 2,
  localparam int unsigned WORDS = BUF_BYTES / WORD_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_fire,
  input  logic          fet_fire,
  input  logic          sto_fire,
  input  logic          rd_fire,
  output logic [AW-1:0] wr_off,
  output logic [WW-1:0] fet_word,
  output logic [WW-1:0] sto_word,
  output logic [AW-1:0] rd_off
);
  localparam logic [AW-1:0] LAST_BYTE = AW'(BUF_BYTES - 1);
  localparam logic [WW-1:0] LAST_BLK  = WW'(WORDS - BLK_WORDS);

  function automatic logic [WW-1:0] next_word(input logic [WW-1:0] w);
    return (w == LAST_BLK) ? '0 : w + WW'(BLK_WORDS);
  endfunction

  function automatic logic [AW-1:0] next_byte(input logic [AW-1:0] b);
    return (b == LAST_BYTE) ? '0 : b + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off   <= '0;
      fet_word <= '0;
      sto_word <= '0;
      rd_off   <= '0;
    end else if (clr) begin
      wr_off   <= '0;
      fet_word <= '0;
      sto_word <= '0;
      rd_off   <= '0;
    end else begin
      if (wr_fire)  wr_off   <= next_byte(wr_off);
      if (fet_fire) fet_word <= next_word(fet_word);
      if (sto_fire) sto_word <= next_word(sto_word);
      if (rd_fire)  rd_off   <= next_byte(rd_off);
    end
  end
endmodule

// File: rtl/inplace_ring_status.sv
module inplace_ring_status
  import inplace_ring_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 256,
  parameter int unsigned LEN_W = 16,
  localparam int unsigned AW = $clog2(BUF_BYTES),
  localparam int unsigned WW = AW - 2,
  localparam int unsigned CW = AW + 1
) (
  input  logic [AW-1:0]    wr_off,
  input  logic [WW-1:0]    fet_word,
  input  logic [WW-1:0]    sto_word,
  input  logic [AW-1:0]    rd_off,
  input  logic [LEN_W-1:0] rd_req_len,
  output logic             can_write,
  output logic             can_fetch,
  output logic             can_store,
  output logic             can_read,
  output logic [CW-1:0]    free_bytes,
  output logic [CW-1:0]    eng_blocks,
  output logic [CW-1:0]    rd_avail,
  output logic             refill_req,
  output logic             drain_req,
  output logic             stall,
  output logic             order_fault
);
  logic [AW-1:0] fet_pos, sto_pos;
  logic [AW-1:0] held, eng_span, in_flight, ready_span;
  logic [AW-1:0] d_sto, d_fet;

  assign fet_pos = {fet_word, 2'b00};
  assign sto_pos = {sto_word, 2'b00};

  // Modular distances; the ring never holds BUF_BYTES bytes, so none is ambiguous.
  assign held       = wr_off - rd_off;
  assign eng_span   = wr_off - fet_pos;
  assign in_flight  = fet_pos - sto_pos;
  assign ready_span = sto_pos - rd_off;
  assign d_sto      = sto_pos - rd_off;
  assign d_fet      = fet_pos - rd_off;

  assign can_write = (held != AW'(BUF_BYTES - 1));
  assign can_fetch = (eng_span[AW-1:4] != '0);
  assign can_store = (in_flight != '0);
  assign can_read  = (ready_span != '0);

  assign free_bytes = CW'(BUF_BYTES - 1) - {1'b0, held};
  assign eng_blocks = CW'(eng_span[AW-1:4]);
  assign rd_avail   = {1'b0, ready_span};

  assign refill_req = (eng_span < AW'(BLK_BYTES));
  assign drain_req  = (ready_span >= AW'(BUF_BYTES - DRAIN_SLACK)) ||
                      (LEN_W'(ready_span) >= rd_req_len);
  assign stall      = !can_fetch && !can_store;
  assign order_fault = (d_sto > d_fet) || (d_fet > held);
endmodule

// File: rtl/inplace_ring.sv
module inplace_ring
  import inplace_ring_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 256,
  parameter int unsigned LEN_W = 16,
  localparam int unsigned AW = $clog2(BUF_BYTES),
  localparam int unsigned WW = AW - 2,
  localparam int unsigned BW = AW - 4,
  localparam int unsigned CW = AW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [7:0]          wr_data,
  output logic                fet_valid,
  input  logic                fet_ready,
  output logic [BLK_BITS-1:0] fet_data,
  input  logic                sto_valid,
  output logic                sto_ready,
  input  logic [BLK_BITS-1:0] sto_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [7:0]          rd_data,
  input  logic [LEN_W-1:0]    rd_req_len,
  output logic [CW-1:0]       free_bytes,
  output logic [CW-1:0]       eng_blocks,
  output logic [CW-1:0]       rd_avail,
  output logic                refill_req,
  output logic                drain_req,
  output logic                stall,
  output logic                order_fault
);
  logic [AW-1:0] wr_off, rd_off;
  logic [WW-1:0] fet_word, sto_word;
  logic wr_fire, fet_fire, sto_fire, rd_fire;

  assign wr_fire  = wr_valid  && wr_ready;
  assign fet_fire = fet_valid && fet_ready;
  assign sto_fire = sto_valid && sto_ready;
  assign rd_fire  = rd_valid  && rd_ready;

  inplace_ring_ptrs #(.BUF_BYTES(BUF_BYTES)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_fire(wr_fire), .fet_fire(fet_fire), .sto_fire(sto_fire), .rd_fire(rd_fire),
    .wr_off(wr_off), .fet_word(fet_word), .sto_word(sto_word), .rd_off(rd_off)
  );

  inplace_ring_status #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_status (
    .wr_off(wr_off), .fet_word(fet_word), .sto_word(sto_word), .rd_off(rd_off),
    .rd_req_len(rd_req_len),
    .can_write(wr_ready), .can_fetch(fet_valid), .can_store(sto_ready), .can_read(rd_valid),
    .free_bytes(free_bytes), .eng_blocks(eng_blocks), .rd_avail(rd_avail),
    .refill_req(refill_req), .drain_req(drain_req), .stall(stall),
    .order_fault(order_fault)
  );

  inplace_ring_store #(.BUF_BYTES(BUF_BYTES)) u_store (
    .clk(clk),
    .byte_we(wr_fire), .byte_waddr(wr_off), .byte_wdata(wr_data),
    .blk_we(sto_fire), .blk_waddr(sto_word[WW-1:2]), .blk_wdata(sto_data),
    .byte_raddr(rd_off), .byte_rdata(rd_data),
    .blk_raddr(fet_word[WW-1:2]), .blk_rdata(fet_data)
  );
endmodule

// File: rtl/inplace_ring_chk.sv
module inplace_ring_chk
  import inplace_ring_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 256,
  localparam int unsigned AW = $clog2(BUF_BYTES),
  localparam int unsigned CW = AW + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr,
  input logic                wr_valid,
  input logic                wr_ready,
  input logic                fet_valid,
  input logic                fet_ready,
  input logic [BLK_BITS-1:0] fet_data,
  input logic                sto_valid,
  input logic                sto_ready,
  input logic                rd_valid,
  input logic                rd_ready,
  input logic [7:0]          rd_data,
  input logic [CW-1:0]       free_bytes,
  input logic [CW-1:0]       eng_blocks,
  input logic [CW-1:0]       rd_avail,
  input logic                refill_req,
  input logic                drain_req,
  input logic                stall,
  input logic                order_fault
);
  // R1: a lone producer write uses exactly one byte of space
  p_free_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !(rd_valid && rd_ready) && !clr) |=>
      (free_bytes == $past(free_bytes) - 1'b1));

  // R3: a lone store makes 16 more bytes readable
  p_store_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sto_valid && sto_ready && !(rd_valid && rd_ready) && !clr) |=>
      (rd_avail == $past(rd_avail) + CW'(BLK_BYTES)));

  // R7: near-full output always asks for draining
  p_drain_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_avail >= CW'(BUF_BYTES - DRAIN_SLACK)) |-> drain_req);

  // R8: a stalled buffer offers the engine nothing
  p_stall_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!fet_valid && !sto_ready && refill_req));

  // R9: legal traffic never breaks pointer order
  p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !order_fault);

  // R10: clear leaves an empty ring
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (free_bytes == CW'(BUF_BYTES - 1) && eng_blocks == '0 &&
             rd_avail == '0 && stall && !rd_valid && wr_ready));

  // R12: held offers keep valid and data
  p_hold_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !clr) |=> (rd_valid && $stable(rd_data)));

  p_hold_fet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_valid && !fet_ready && !clr) |=> (fet_valid && $stable(fet_data)));
endmodule

bind inplace_ring inplace_ring_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr),
  .wr_valid(wr_valid), .wr_ready(wr_ready),
  .fet_valid(fet_valid), .fet_ready(fet_ready), .fet_data(fet_data),
  .sto_valid(sto_valid), .sto_ready(sto_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .free_bytes(free_bytes), .eng_blocks(eng_blocks), .rd_avail(rd_avail),
  .refill_req(refill_req), .drain_req(drain_req), .stall(stall),
  .order_fault(order_fault)
);

// File: tb/inplace_ring_test.sv
`timescale 1ns/1ps
module inplace_ring_test;
  localparam int BUF = 256;
  localparam int LEN_W = 16;
  localparam int CW = $clog2(BUF) + 1;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic fet_valid, fet_ready = 1'b0;
  logic [127:0] fet_data;
  logic sto_valid = 1'b0, sto_ready;
  logic [127:0] sto_data = '0;
  logic rd_valid, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic [LEN_W-1:0] rd_req_len = LEN_W'(BUF);
  logic [CW-1:0] free_bytes, eng_blocks, rd_avail;
  logic refill_req, drain_req, stall, order_fault;

  always #2.5 clk = ~clk;

  inplace_ring #(.BUF_BYTES(BUF), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .fet_valid(fet_valid), .fet_ready(fet_ready), .fet_data(fet_data),
    .sto_valid(sto_valid), .sto_ready(sto_ready), .sto_data(sto_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_req_len(rd_req_len),
    .free_bytes(free_bytes), .eng_blocks(eng_blocks), .rd_avail(rd_avail),
    .refill_req(refill_req), .drain_req(drain_req), .stall(stall),
    .order_fault(order_fault)
  );

  int n_checks = 0, n_fail = 0;
  int nw = 0, nf = 0, ns = 0, nr = 0, epoch = 0;
  bit done = 1'b0;
  logic [127:0] eng_q[$];

  function automatic logic [7:0] pat(int p);
    return 8'((p * 37) ^ (p >> 5) ^ (epoch * 91) ^ 7);
  endfunction

  function automatic logic [127:0] exp_blk(int blk);
    logic [127:0] b;
    for (int j = 0; j < 16; j++) b[8*j +: 8] = pat(blk * 16 + j);
    return b;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic check_status();
    int used, eng_av, cons;
    bit exp_fv, exp_drain;
    used = nw - nr; eng_av = nw - nf * 16; cons = ns * 16 - nr;
    exp_fv = (eng_av >= 16);
    exp_drain = (cons >= BUF - 32) || (cons >= int'(rd_req_len));
    chk(wr_ready == (used < BUF - 1), "R1", "wr_ready", 128'(wr_ready), 128'(used < BUF - 1));
    chk(free_bytes == CW'(BUF - 1 - used), "R11", "free_bytes", 128'(free_bytes), 128'(BUF - 1 - used));
    chk(fet_valid == exp_fv, "R2", "fet_valid", 128'(fet_valid), 128'(exp_fv));
    chk(eng_blocks == CW'(eng_av / 16), "R11", "eng_blocks", 128'(eng_blocks), 128'(eng_av / 16));
    chk(sto_ready == (nf > ns), "R3", "sto_ready", 128'(sto_ready), 128'(nf > ns));
    chk(rd_valid == (cons > 0), "R4", "rd_valid", 128'(rd_valid), 128'(cons > 0));
    chk(rd_avail == CW'(cons), "R11", "rd_avail", 128'(rd_avail), 128'(cons));
    chk(refill_req == !exp_fv, "R6", "refill_req", 128'(refill_req), 128'(!exp_fv));
    chk(drain_req == exp_drain, "R7", "drain_req", 128'(drain_req), 128'(exp_drain));
    chk(stall == (!exp_fv && nf == ns), "R8", "stall", 128'(stall), 128'(!exp_fv && nf == ns));
    chk(order_fault == 1'b0, "R9", "order_fault", 128'(order_fault), 128'(0));
    if (fet_valid && exp_fv)
      chk(fet_data == exp_blk(nf), (nf * 16 >= BUF) ? "R5" : "R2", "fet_data",
          fet_data, exp_blk(nf));
    if (rd_valid && cons > 0)
      chk(rd_data == (pat(nr) ^ 8'h5A), (nr >= BUF) ? "R5" : "R4", "rd_data",
          128'(rd_data), 128'(pat(nr) ^ 8'h5A));
  endtask

  task automatic cycle(bit w, bit f, bit s, bit r);
    bit wf, ff, sf, rf;
    @(negedge clk);
    check_status();
    wr_valid  = w; wr_data = pat(nw);
    fet_ready = f;
    sto_valid = s && (eng_q.size() > 0);
    sto_data  = (eng_q.size() > 0) ? eng_q[0] : '0;
    rd_ready  = r;
    wf = wr_valid && wr_ready; ff = fet_valid && fet_ready;
    sf = sto_valid && sto_ready; rf = rd_valid && rd_ready;
    @(posedge clk);
    if (wf) nw++;
    if (ff) begin
      logic [127:0] b;
      b = exp_blk(nf);
      eng_q.push_back(b ^ {16{8'h5A}});
      nf++;
    end
    if (sf) begin void'(eng_q.pop_front()); ns++; end
    if (rf) nr++;
  endtask

  task automatic do_clear();
    @(negedge clk);
    wr_valid = 0; fet_ready = 0; sto_valid = 0; rd_ready = 0; clr = 1;
    @(posedge clk);
    nw = 0; nf = 0; ns = 0; nr = 0; epoch++; eng_q.delete();
    @(negedge clk);
    clr = 0;
    chk(free_bytes == CW'(BUF - 1) && rd_avail == 0 && eng_blocks == 0, "R10",
        "clear counts", 128'({free_bytes, rd_avail, eng_blocks}), 128'({CW'(BUF - 1), CW'(0), CW'(0)}));
    chk(stall && refill_req && !rd_valid, "R10", "clear flags",
        128'({stall, refill_req, rd_valid}), 128'(3'b110));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_status();
    // R1: fill to the last usable byte
    for (int i = 0; i < BUF + 8; i++) cycle(1, 0, 0, 0);
    @(negedge clk);
    chk(!wr_ready && free_bytes == 0 && nw == BUF - 1, "R1", "full ring",
        128'({wr_ready, free_bytes}), 128'(0));
    // R12: offered block held while engine waits
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0);
    // process every whole block: 240 ready, 15 leftover
    for (int i = 0; i < 60; i++) cycle(0, 1, 1, 0);
    @(negedge clk);
    chk(drain_req && stall && refill_req && rd_avail == CW'(240), "R7",
        "near-full drain", 128'({drain_req, stall, refill_req, rd_avail}),
        128'({3'b111, CW'(240)}));
    // R12: held consumer byte
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0);
    for (int i = 0; i < BUF; i++) cycle(0, 0, 0, 1);
    // random traffic with repeated wrap (R5)
    for (int i = 0; i < 5000; i++) begin
      if (i % 64 == 0) rd_req_len = LEN_W'($urandom_range(0, BUF));
      cycle($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
            $urandom_range(0, 2) != 0, $urandom_range(0, 3) != 0);
    end
    chk(nr > 4 * BUF, "R5", "wrap coverage", 128'(nr), 128'(4 * BUF));
    do_clear();
    for (int i = 0; i < 1500; i++)
      cycle($urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0,
            $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule